// File: doc/BRIEF.md
# Mode-Selectable Program Bank Mapper

This block translates CPU addresses in the range 0x6000 to 0xFFFF into physical 8 KB program-ROM page numbers. Software programs four 8-bit bank registers, a control register and an outer-bank register through a small write port. The control register picks one of eight banking layouts. Between them the layouts give 32 KB, 16 KB or 8 KB granularity, with the last window either fixed or switchable. The outer-bank register adds the high page bits that select a 512 KB or 256 KB region.

Control bit 7 can also map a ROM page into the 0x6000 to 0x7FFF window. That page is derived from bank register 3, scaled to the granularity of the selected layout. The mapping path is purely combinational from the registers and the CPU address. Register writes are captured on the rising clock edge.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset all four bank registers hold 0xFF and the control and outer registers hold 0, so 0x8000, 0xA000, 0xC000 and 0xE000 map to pages 28, 29, 30 and 31, and lowWinEn is 0.
- R2: A write with wrEn=1 is captured on the rising clock edge, and the outputs reflect it from that edge onward. The write encoding is: wrAddr[2]=0 writes bank register wrAddr[1:0]; wrAddr[2]=1 with wrAddr[0]=0 writes the control register; wrAddr[2]=1 with wrAddr[0]=1 writes the outer register.
- R3: When control[2:0]=0, the page for address 0x8000 plus k*0x2000 (k=0..3) is 4*((bank3 & 7) | (outer[2:0] << 3)) + k.
- R4: When control[2:0]=1, windows 0 and 1 use 16 KB bank (bank1 & 15) | (outer[2:0] << 4), and windows 2 and 3 use 16 KB bank 15 | (outer[2:0] << 4). The page is 2*bank + (k & 1).
- R5: When control[2:0] is 2 or 3, window k<3 maps page (bankk & 31) | (outer[2:0] << 5), and window 3 maps page 31 | (outer[2:0] << 5).
- R6: When control[2:0]=4, the page for window k is 4*((bank3 & 15) | (outer[2:1] << 4)) + k.
- R7: When control[2:0]=5, windows 0 and 1 use 16 KB bank (bank1 & 31) | (outer[2:1] << 5), and windows 2 and 3 use (bank3 & 31) | (outer[2:1] << 5). The page is 2*bank + (k & 1).
- R8: When control[2:0] is 6 or 7, window k maps page (bankk & 63) | (outer[2:1] << 6).
- R9: When control bit 7 is 1, an address in 0x6000 to 0x7FFF sets lowWinEn=1 and maps a page with the upper field taken from the outer register. In modes 0 and 4 the page is ((4*bank3+3) & 63) | (outer[2:1] << 6). In modes 1 and 5 it is ((2*bank3+1) & 63) | (outer[2:1] << 6). In modes 2 and 3 it is (bank3 & 31) | (outer[2:0] << 5). In modes 6 and 7 it is (bank3 & 63) | (outer[2:1] << 6).
- R10: For addresses below 0x6000, and for 0x6000 to 0x7FFF while control bit 7 is 0, pageNum is 0 and lowWinEn is 0.
- R11: While wrEn is 0, no register changes, whatever wrAddr and wrData carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select (see R2) |
| wrData | input | 8 | Write data |
| cpuAddr | input | 16 | CPU address being mapped |
| pageNum | output | 8 | Physical 8 KB page number |
| lowWinEn | output | 1 | ROM is mapped for the current 0x6000 to 0x7FFF access |

## Verification
Register writes take one clock edge. The bench drives each write at a falling edge and looks for its effect only after the next rising edge. It also confirms that the old mapping still stands just before that edge. Address-to-page translation has no register in its path, so after changing cpuAddr the bench waits one time unit and then compares against an arithmetic model. Layouts, outer values, enable settings and bank patterns are swept together.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_BANKS = 4;
  localparam int IDX_W     = $clog2(NUM_BANKS);
  localparam int ADDR_W    = 16;
  localparam int SEL_W     = IDX_W + 1;

  typedef struct packed {
    logic              bankWe;
    logic [IDX_W-1:0]  bankIdx;
    logic [DATA_W-1:0] data;
  } bank_wr_t;
endpackage

// File: rtl/prg_map_ctrl.sv
module prg_map_ctrl
  import prg_map_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output bank_wr_t          bankWr,
  output logic [2:0]        modeSel,
  output logic              lowMapOn,
  output logic [2:0]        outerSel
);
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] outerReg;
  logic ctrlWe;
  logic outerWe;

  assign ctrlWe  = wrEn &&  wrAddr[SEL_W-1] && !wrAddr[0];
  assign outerWe = wrEn &&  wrAddr[SEL_W-1] &&  wrAddr[0];

  always_comb begin
    bankWr.bankWe  = wrEn && !wrAddr[SEL_W-1];
    bankWr.bankIdx = wrAddr[IDX_W-1:0];
    bankWr.data    = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      outerReg <= '0;
    end else begin
      if (ctrlWe)  ctrlReg  <= wrData;
      if (outerWe) outerReg <= wrData;
    end
  end

  assign modeSel  = ctrlReg[2:0];
  assign lowMapOn = ctrlReg[DATA_W-1];
  assign outerSel = outerReg[2:0];

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^{ctrlReg[DATA_W-2:3], outerReg[DATA_W-1:3]};

  // R2: a control write lands on the next edge
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && wrEn && wrAddr[SEL_W-1] && !wrAddr[0])
      |=> (modeSel == $past(wrData[2:0]) && lowMapOn == $past(wrData[DATA_W-1])));
  // R11: no write strobe keeps the mode registers
  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !wrEn) |=> ($stable(modeSel) && $stable(lowMapOn) && $stable(outerSel)));
endmodule

// File: rtl/prg_map_datapath.sv
module prg_map_datapath
  import prg_map_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bank_wr_t          bankWr,
  input  logic [2:0]        modeSel,
  input  logic              lowMapOn,
  input  logic [2:0]        outerSel,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [7:0]        pageNum,
  output logic              lowWinEn
);
  logic [DATA_W-1:0] bankReg [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) bankReg[i] <= '1;
      else if (bankWr.bankWe && bankWr.bankIdx == IDX_W'(i)) bankReg[i] <= bankWr.data;
    end

    // R2: a bank write lands on the next edge
    assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && bankWr.bankWe && bankWr.bankIdx == IDX_W'(i))
        |=> (bankReg[i] == $past(bankWr.data)));
    // R11: without a matching strobe the register holds
    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !(bankWr.bankWe && bankWr.bankIdx == IDX_W'(i))) |=> $stable(bankReg[i]));
  end

  logic [1:0] win;
  logic       romHalf;
  logic       inLowWin;
  logic [1:0] outerHi;
  logic [DATA_W-1:0] winBank;
  logic [DATA_W-1:0] b1;
  logic [DATA_W-1:0] b3;
  logic [7:0] upperPage;
  logic [7:0] lowPage;

  assign win      = cpuAddr[14:13];
  assign romHalf  = cpuAddr[15];
  assign inLowWin = (cpuAddr[15:13] == 3'b011);
  assign outerHi  = outerSel[2:1];
  assign winBank  = bankReg[win];
  assign b1       = bankReg[1];
  assign b3       = bankReg[3];

  always_comb begin
    upperPage = '0;
    lowPage   = '0;
    case (modeSel)
      3'd0: begin
        upperPage = {outerSel, b3[2:0], win};
        lowPage   = {outerHi, b3[3:0], 2'b11};
      end
      3'd1: begin
        upperPage = win[1] ? {outerSel, 4'hF, win[0]} : {outerSel, b1[3:0], win[0]};
        lowPage   = {outerHi, b3[4:0], 1'b1};
      end
      3'd2, 3'd3: begin
        upperPage = (win == 2'd3) ? {outerSel, 5'h1F} : {outerSel, winBank[4:0]};
        lowPage   = {outerSel, b3[4:0]};
      end
      3'd4: begin
        upperPage = {outerHi, b3[3:0], win};
        lowPage   = {outerHi, b3[3:0], 2'b11};
      end
      3'd5: begin
        upperPage = win[1] ? {outerHi, b3[4:0], win[0]} : {outerHi, b1[4:0], win[0]};
        lowPage   = {outerHi, b3[4:0], 1'b1};
      end
      default: begin
        upperPage = {outerHi, winBank[5:0]};
        lowPage   = {outerHi, b3[5:0]};
      end
    endcase
  end

  always_comb begin
    lowWinEn = inLowWin && lowMapOn;
    if (romHalf)       pageNum = upperPage;
    else if (lowWinEn) pageNum = lowPage;
    else               pageNum = '0;
  end

  logic unusedBankBits;
  assign unusedBankBits = ^{b1[DATA_W-1:5], winBank[DATA_W-1:6], b3[DATA_W-1:6]};

  // R10: nothing is mapped below the low window
  assert_quiet_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:13] < 3'b011) |-> (pageNum == 8'd0 && !lowWinEn));
  // R5: fixed last 8 KB page in the 8 KB layouts
  assert_fixed_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[2:1] == 2'b01 && cpuAddr[15:13] == 3'b111) |-> (pageNum[4:0] == 5'h1F));
  // R4: fixed upper 16 KB bank in mode 1
  assert_fixed_half_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd1 && cpuAddr[15:14] == 2'b11) |-> (pageNum[4:1] == 4'hF));
  // R9: the low-window flag only rises inside its window
  assert_low_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    lowWinEn |-> (cpuAddr[15:13] == 3'b011 && lowMapOn));
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [7:0]        pageNum,
  output logic              lowWinEn
);
  bank_wr_t   bankWr;
  logic [2:0] modeSel;
  logic       lowMapOn;
  logic [2:0] outerSel;

  prg_map_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .bankWr(bankWr), .modeSel(modeSel), .lowMapOn(lowMapOn), .outerSel(outerSel)
  );

  prg_map_datapath u_dp (
    .clk(clk), .rstN(rstN), .bankWr(bankWr), .modeSel(modeSel), .lowMapOn(lowMapOn),
    .outerSel(outerSel), .cpuAddr(cpuAddr), .pageNum(pageNum), .lowWinEn(lowWinEn)
  );
endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  pageNum;
  logic        lowWinEn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  prg_bank_mapper dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int mCtrl, mOuter;
  int mBank [4];

  task automatic writeReg(input int sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(sel); wrData = 8'(val);
    @(negedge clk);
    wrEn = 1'b0;
    if (sel < 4) mBank[sel] = val & 255;
    else if ((sel & 1) == 0) mCtrl = val & 255;
    else mOuter = val & 255;
  endtask

  function automatic int expPage(input int addr);
    int m, o, o21, w, bk, r;
    m = mCtrl & 7; o = mOuter & 7; o21 = (mOuter >> 1) & 3; w = (addr >> 13) & 3;
    r = 0;
    if (addr >= 32768) begin
      case (m)
        0: r = ((mBank[3] & 7) + o * 8) * 4 + w;
        1: begin
          bk = (w < 2) ? (mBank[1] & 15) : 15;
          r = (bk + o * 16) * 2 + (w & 1);
        end
        2, 3: r = ((w == 3) ? 31 : (mBank[w] & 31)) + o * 32;
        4: r = ((mBank[3] & 15) + o21 * 16) * 4 + w;
        5: begin
          bk = (w < 2) ? mBank[1] : mBank[3];
          r = ((bk & 31) + o21 * 32) * 2 + (w & 1);
        end
        default: r = (mBank[w] & 63) + o21 * 64;
      endcase
    end else if (addr >= 24576 && (mCtrl & 128) != 0) begin
      case (m)
        0, 4: r = ((mBank[3] * 4 + 3) & 63) + o21 * 64;
        1, 5: r = ((mBank[3] * 2 + 1) & 63) + o21 * 64;
        2, 3: r = (mBank[3] & 31) + o * 32;
        default: r = (mBank[3] & 63) + o21 * 64;
      endcase
    end
    return r & 255;
  endfunction

  function automatic string reqOf(input int addr);
    if (addr < 24576 || (addr < 32768 && (mCtrl & 128) == 0)) return "R10";
    if (addr < 32768) return "R9";
    case (mCtrl & 7)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe(input int addr, input string req);
    int expEn;
    cpuAddr = 16'(addr);
    #1;
    expEn = (addr >= 24576 && addr < 32768 && (mCtrl & 128) != 0) ? 1 : 0;
    checkVal(req, int'(pageNum), expPage(addr));
    checkVal(req, int'(lowWinEn), expEn);
  endtask

  int addrList [8] = '{16'h0000, 16'h5FFF, 16'h6000, 16'h7FFF,
                       16'h8000, 16'hA123, 16'hC000, 16'hFFFF};

  initial begin
    mCtrl = 0; mOuter = 0;
    for (int i = 0; i < 4; i++) mBank[i] = 255;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      cpuAddr = 16'(32768 + k * 8192); #1;
      checkVal("R1", int'(pageNum), 28 + k);
    end
    cpuAddr = 16'h6000; #1;
    checkVal("R1", int'(lowWinEn), 0);

    // R2: timing of a write; the old value holds until the edge
    cpuAddr = 16'h8000;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd3; wrData = 8'h02;
    @(posedge clk); #0;
    checkVal("R2", int'(pageNum), 28);
    #1;
    checkVal("R2", int'(pageNum), 8);
    @(negedge clk);
    wrEn = 1'b0;
    mBank[3] = 2;

    // R11: data on the port without wrEn is ignored
    @(negedge clk);
    wrAddr = 3'd3; wrData = 8'h55;
    @(negedge clk);
    wrAddr = 3'd4; wrData = 8'h86;
    @(negedge clk);
    wrAddr = 3'd5; wrData = 8'h07;
    @(negedge clk);
    cpuAddr = 16'h8000; #1;
    checkVal("R11", int'(pageNum), 8);
    cpuAddr = 16'h6000; #1;
    checkVal("R11", int'(lowWinEn), 0);

    // R3..R10: sweep layouts, enable, outer value and bank patterns
    for (int m = 0; m < 8; m++) begin
      for (int en = 0; en < 2; en++) begin
        for (int o = 0; o < 8; o++) begin
          for (int s = 0; s < 4; s++) begin
            writeReg(4, m + en * 128 + ((s * 3 + o) & 15) * 8);
            writeReg(5, o + s * 40);
            for (int i = 0; i < 4; i++)
              writeReg(i, (s * 55 + i * 91 + o * 29 + m * 13 + 17) & 255);
            foreach (addrList[a]) probe(addrList[a], reqOf(addrList[a]));
          end
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule